// File: doc/BRIEF.md
# Five-Stage Forwarding Integer Pipeline

This block is an in-order integer core that splits each instruction across five stages: fetch, decode with register read, execute, memory access and write-back. It runs a 64-bit load/store subset with four register-to-register operations and one equality branch. The instruction port and the data port are independent, so a fetch and a data access can happen in the same cycle.

Results leave the ALU and reach the next dependent instruction without waiting for write-back. Two cases cannot be covered that way, and the core stalls for them. A value loaded from memory and needed by the very next instruction costs one bubble. A branch holds fetch until the branch has been evaluated in execute. The surrounding system supplies both memories. Instruction read data must follow the fetch address within the same cycle, and data read data must follow the data address within the same cycle.

Top module: `pipe5_core`

## Requirements
- R1: A synchronous active-high `rst` empties the pipeline and sets the fetch address to 0. While reset is held, `imem_addr` is 0 and `dmem_we` is 0. Register contents are not cleared.
- R2: Instruction encodings follow the usual 32-bit layout (opcode in bits 6:0, rd in 11:7, funct3 in 14:12, rs1 in 19:15, rs2 in 24:20, funct7 in 31:25). The decoded operations are:
  - load doubleword: opcode 0000011, funct3 011
  - store doubleword: opcode 0100011, funct3 011
  - register-to-register: opcode 0110011 with funct7/funct3 of 0000000/000 for add, 0100000/000 for subtract, 0000000/111 for AND and 0000000/110 for OR
  - branch if equal: opcode 1100011, funct3 000

  Any other word occupies one issue slot and changes no register or memory.
- R3: An ALU result is forwarded to the instruction directly behind it and to the instruction two behind it, with no stall.
- R4: When both of the two older instructions in flight write the register being read, the younger one's value is used.
- R5: Register x0 always reads as zero. Writes to x0 are dropped, and an instruction that names x0 as its destination is never a forwarding source.
- R6: A register written back in a cycle is seen by an instruction reading it in decode in that same cycle.
- R7: Decode issue timing: each instruction enters decode one cycle after the one before it. When the one before is a load whose nonzero destination the new instruction reads as a source, exactly one extra cycle is added. Source use by operation: rs1 and rs2 for register-to-register ops, stores and branches; rs1 alone for loads.
- R8: A branch resolves in execute, and the next instruction enters decode three cycles after the branch did. If the two operands are equal, fetch goes to branch address + sign-extended 13-bit offset, where offset bit 12 is instruction bit 31, bit 11 is bit 7, bits 10:5 are bits 30:25, bits 4:1 are bits 11:8, and bit 0 is 0. Otherwise fetch goes to branch address + 4.
- R9: The load or store address is rs1 plus the sign-extended 12-bit offset. For loads the offset is instruction bits 31:20; for stores it is bits 31:25 above bits 11:7. A store that is in decode in cycle n drives `dmem_we`, `dmem_addr` and `dmem_wdata` in cycle n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | XLEN | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | XLEN | Byte address of the data access in the memory stage |
| dmem_wdata | output | XLEN | Store data |
| dmem_we | output | 1 | Store strobe, written at the next rising edge |
| dmem_rdata | input | XLEN | Data word at `dmem_addr`, same cycle |

## Verification
The hardest state to reach from the ports is one where several hazard mechanisms overlap in a single cycle. Examples are a load feeding a branch compare, so the interlock and the branch hold stack; a load feeding the address of the next load; and a register written by both older in-flight instructions. Directed programs build each of these on purpose. A loop that leaves through a backward branch and a forward branch checks both offset signs. Randomly drawn straight-line programs over a small register set then produce dense chains of dependences. The bench compares every cycle's store port, including when each store occurs, against an instruction-level model that derives issue cycles from the timing rules alone.

// File: rtl/p5_pkg.sv
package p5_pkg;
  localparam int REG_AW = 5;

  localparam logic [6:0] OP_LOAD  = 7'b0000011;
  localparam logic [6:0] OP_STORE = 7'b0100011;
  localparam logic [6:0] OP_ARITH = 7'b0110011;
  localparam logic [6:0] OP_BRANCH = 7'b1100011;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;
  typedef enum logic [1:0] {FW_REG, FW_EXMEM, FW_MEMWB} fwd_e;

  typedef struct packed {
    logic    reg_wr;
    logic    mem_rd;
    logic    mem_wr;
    logic    is_br;
    logic    use_imm;
    alu_op_e alu;
  } ctl_t;

  localparam ctl_t CTL_NOP = '{reg_wr: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0,
                               is_br: 1'b0, use_imm: 1'b0, alu: ALU_ADD};
endpackage

// File: rtl/p5_decode.sv
module p5_decode
  import p5_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]       instr,
  input  logic              valid,
  output ctl_t              ctl,
  output logic [REG_AW-1:0] rs [2],
  output logic [REG_AW-1:0] rd,
  output logic [XLEN-1:0]   imm,
  output logic [1:0]        use_rs
);
  logic [6:0] op;
  logic [2:0] f3;
  logic [6:0] f7;

  assign op    = instr[6:0];
  assign f3    = instr[14:12];
  assign f7    = instr[31:25];
  assign rs[0] = instr[19:15];
  assign rs[1] = instr[24:20];
  assign rd    = instr[11:7];

  always_comb begin
    ctl    = CTL_NOP;
    use_rs = 2'b00;
    imm    = '0;
    if (valid) begin
      if (op == OP_LOAD && f3 == 3'b011) begin
        ctl.reg_wr  = 1'b1;
        ctl.mem_rd  = 1'b1;
        ctl.use_imm = 1'b1;
        use_rs      = 2'b01;
        imm         = {{(XLEN-12){instr[31]}}, instr[31:20]};
      end else if (op == OP_STORE && f3 == 3'b011) begin
        ctl.mem_wr  = 1'b1;
        ctl.use_imm = 1'b1;
        use_rs      = 2'b11;
        imm         = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
      end else if (op == OP_BRANCH && f3 == 3'b000) begin
        ctl.is_br = 1'b1;
        ctl.alu   = ALU_SUB;
        use_rs    = 2'b11;
        imm       = {{(XLEN-12){instr[31]}}, instr[31], instr[7],
                     instr[30:25], instr[11:8]};
      end else if (op == OP_ARITH) begin
        if (f7 == 7'h00 && f3 == 3'b000) begin
          ctl.reg_wr = 1'b1; ctl.alu = ALU_ADD; use_rs = 2'b11;
        end else if (f7 == 7'h20 && f3 == 3'b000) begin
          ctl.reg_wr = 1'b1; ctl.alu = ALU_SUB; use_rs = 2'b11;
        end else if (f7 == 7'h00 && f3 == 3'b111) begin
          ctl.reg_wr = 1'b1; ctl.alu = ALU_AND; use_rs = 2'b11;
        end else if (f7 == 7'h00 && f3 == 3'b110) begin
          ctl.reg_wr = 1'b1; ctl.alu = ALU_OR;  use_rs = 2'b11;
        end
      end
    end
  end
endmodule

// File: rtl/p5_regfile.sv
module p5_regfile #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [AW-1:0]   ra [NRD],
  output logic [XLEN-1:0] rdata [NRD]
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) mem[wa] <= wd;
  end

  // write-before-read: the value being written this cycle wins over storage
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (ra[g] == '0)            ? '0 :
                      (we && wa == ra[g])      ? wd : mem[ra[g]];
  end
endmodule

// File: rtl/p5_fwd.sv
module p5_fwd
  import p5_pkg::*;
(
  input  logic [REG_AW-1:0] src,
  input  logic              mm_wr,
  input  logic              mm_ld,
  input  logic [REG_AW-1:0] mm_rd,
  input  logic              wb_wr,
  input  logic [REG_AW-1:0] wb_rd,
  output fwd_e              sel
);
  always_comb begin
    if (mm_wr && !mm_ld && mm_rd != '0 && mm_rd == src) sel = FW_EXMEM;
    else if (wb_wr && wb_rd != '0 && wb_rd == src)      sel = FW_MEMWB;
    else                                                sel = FW_REG;
  end
endmodule

// File: rtl/p5_hazard.sv
module p5_hazard
  import p5_pkg::*;
(
  input  logic [REG_AW-1:0] rs [2],
  input  logic [1:0]        use_rs,
  input  logic              ex_ld,
  input  logic [REG_AW-1:0] ex_rd,
  output logic              ld_stall
);
  logic [1:0] hit;

  for (genvar g = 0; g < 2; g++) begin : g_cmp
    assign hit[g] = use_rs[g] && (rs[g] == ex_rd);
  end

  assign ld_stall = ex_ld && (ex_rd != '0) && (|hit);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import p5_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  // fetch and IF/ID
  logic [XLEN-1:0]   pc_q;
  logic              ifid_v;
  logic [31:0]       ifid_ins;
  logic [XLEN-1:0]   ifid_pc;

  // decode outputs
  ctl_t              id_ctl;
  logic [REG_AW-1:0] id_rs [2];
  logic [REG_AW-1:0] id_rd;
  logic [XLEN-1:0]   id_imm;
  logic [1:0]        id_use;
  logic [XLEN-1:0]   id_rv [2];
  logic              ld_stall;

  // ID/EX
  ctl_t              ex_ctl;
  logic [XLEN-1:0]   ex_pc, ex_imm;
  logic [XLEN-1:0]   ex_rv [2];
  logic [REG_AW-1:0] ex_rs [2];
  logic [REG_AW-1:0] ex_rd;
  logic [1:0]        ex_use;

  // EX/MEM
  logic              mm_wr, mm_ld, mm_st;
  logic [REG_AW-1:0] mm_rd;
  logic [XLEN-1:0]   mm_alu, mm_sdata;

  // MEM/WB
  logic              wb_wr;
  logic [REG_AW-1:0] wb_rd;
  logic [XLEN-1:0]   wb_val;

  // execute datapath
  logic [XLEN-1:0]   ex_op [2];
  logic [XLEN-1:0]   alu_b, alu_y, br_next;
  logic              br_taken;

  p5_decode #(.XLEN(XLEN)) u_dec (
    .instr(ifid_ins), .valid(ifid_v), .ctl(id_ctl), .rs(id_rs),
    .rd(id_rd), .imm(id_imm), .use_rs(id_use)
  );

  p5_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(2)) u_rf (
    .clk(clk), .we(wb_wr), .wa(wb_rd), .wd(wb_val),
    .ra(id_rs), .rdata(id_rv)
  );

  p5_hazard u_haz (
    .rs(id_rs), .use_rs(id_use), .ex_ld(ex_ctl.mem_rd), .ex_rd(ex_rd),
    .ld_stall(ld_stall)
  );

  for (genvar g = 0; g < 2; g++) begin : g_fwd
    fwd_e sel;
    p5_fwd u_fwd (
      .src(ex_rs[g]), .mm_wr(mm_wr), .mm_ld(mm_ld), .mm_rd(mm_rd),
      .wb_wr(wb_wr), .wb_rd(wb_rd), .sel(sel)
    );
    assign ex_op[g] = (sel == FW_EXMEM) ? mm_alu :
                      (sel == FW_MEMWB) ? wb_val : ex_rv[g];
  end

  always_comb begin
    alu_b = ex_ctl.use_imm ? ex_imm : ex_op[1];
    unique case (ex_ctl.alu)
      ALU_SUB: alu_y = ex_op[0] - alu_b;
      ALU_AND: alu_y = ex_op[0] & alu_b;
      ALU_OR:  alu_y = ex_op[0] | alu_b;
      default: alu_y = ex_op[0] + alu_b;
    endcase
    br_taken = ex_ctl.is_br && (alu_y == '0);
    br_next  = br_taken ? ex_pc + (ex_imm << 1) : ex_pc + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= RESET_PC;
      ifid_v <= 1'b0;
      ex_ctl <= CTL_NOP;
      ex_use <= 2'b00;
      mm_wr  <= 1'b0;
      mm_ld  <= 1'b0;
      mm_st  <= 1'b0;
      wb_wr  <= 1'b0;
    end else begin
      // front end: interlock holds, branch in EX redirects, branch in ID holds
      if (ld_stall) begin
        pc_q <= pc_q;
      end else if (ex_ctl.is_br) begin
        pc_q   <= br_next;
        ifid_v <= 1'b0;
      end else if (id_ctl.is_br) begin
        ifid_v <= 1'b0;
      end else begin
        pc_q     <= pc_q + STEP;
        ifid_v   <= 1'b1;
        ifid_ins <= imem_rdata;
        ifid_pc  <= pc_q;
      end
      // ID/EX: a bubble clears every control field
      ex_ctl <= ld_stall ? CTL_NOP : id_ctl;
      ex_use <= ld_stall ? 2'b00   : id_use;
      ex_pc  <= ifid_pc;
      ex_imm <= id_imm;
      ex_rv  <= id_rv;
      ex_rs  <= id_rs;
      ex_rd  <= id_rd;
      // EX/MEM
      mm_wr    <= ex_ctl.reg_wr;
      mm_ld    <= ex_ctl.mem_rd;
      mm_st    <= ex_ctl.mem_wr;
      mm_rd    <= ex_rd;
      mm_alu   <= alu_y;
      mm_sdata <= ex_op[1];
      // MEM/WB
      wb_wr  <= mm_wr;
      wb_rd  <= mm_rd;
      wb_val <= mm_ld ? dmem_rdata : mm_alu;
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = mm_alu;
  assign dmem_wdata = mm_sdata;
  assign dmem_we    = mm_st;

  // one bubble is always enough: the load has moved to MEM by the next cycle
  assert_loaduse_single_R7: assert property (@(posedge clk) disable iff (rst)
    ld_stall |=> !ld_stall);

  // a load in MEM never has a consumer in EX, so no stale operand is used
  assert_no_load_consumer_R7: assert property (@(posedge clk) disable iff (rst)
    (mm_ld && mm_rd != '0) |->
      !((ex_use[0] && ex_rs[0] == mm_rd) || (ex_use[1] && ex_rs[1] == mm_rd)));

  // while a branch evaluates, decode holds only a bubble
  assert_branch_shadow_R8: assert property (@(posedge clk) disable iff (rst)
    ex_ctl.is_br |-> !ifid_v);

  // a store drives the data port and never writes a register
  assert_store_no_wb_R9: assert property (@(posedge clk) disable iff (rst)
    mm_st |-> !mm_wr && !mm_ld);
endmodule

// File: tb/sim_pipe5_core.sv
module sim_pipe5_core;
  localparam int RUN  = 400;
  localparam int MAXC = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
  logic [31:0] imem_rdata;
  logic        dmem_we;

  logic [31:0] im [256];
  logic [63:0] dm [64];
  string       itag [256];
  int          np;

  bit          ewe [MAXC];
  logic [63:0] ea [MAXC];
  logic [63:0] ed [MAXC];
  string       ereq [MAXC];

  int n_chk = 0;
  int n_bad = 0;
  int cyc;

  always #2 clk = ~clk;

  pipe5_core u0 (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = (imem_addr[63:10] == '0) ? im[imem_addr[9:2]] : 32'h0;
  assign dmem_rdata = dm[dmem_addr[8:3]];

  always @(posedge clk) begin
    if (dmem_we) dm[dmem_addr[8:3]] <= dmem_wdata;
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // encoders
  function automatic logic [31:0] e_r(input logic [6:0] f7, input int b,
                                      input int a, input logic [2:0] f3, input int d);
    return {f7, 5'(b), 5'(a), f3, 5'(d), 7'b0110011};
  endfunction
  function automatic logic [31:0] e_add(input int d, input int a, input int b);
    return e_r(7'h00, b, a, 3'b000, d);
  endfunction
  function automatic logic [31:0] e_sub(input int d, input int a, input int b);
    return e_r(7'h20, b, a, 3'b000, d);
  endfunction
  function automatic logic [31:0] e_and(input int d, input int a, input int b);
    return e_r(7'h00, b, a, 3'b111, d);
  endfunction
  function automatic logic [31:0] e_or(input int d, input int a, input int b);
    return e_r(7'h00, b, a, 3'b110, d);
  endfunction
  function automatic logic [31:0] e_ld(input int d, input int a, input int off);
    logic [11:0] i = 12'(off);
    return {i, 5'(a), 3'b011, 5'(d), 7'b0000011};
  endfunction
  function automatic logic [31:0] e_sd(input int b, input int a, input int off);
    logic [11:0] i = 12'(off);
    return {i[11:5], 5'(b), 5'(a), 3'b011, i[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_beq(input int a, input int b, input int off);
    logic [12:0] o = 13'(off);
    return {o[12], o[10:5], 5'(b), 5'(a), 3'b000, o[4:1], o[11], 7'b1100011};
  endfunction

  task automatic put(input logic [31:0] w, input string tag);
    im[np] = w; itag[np] = tag; np++;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin im[i] = 32'h0; itag[i] = "R2"; end
    for (int i = 0; i < 64; i++) dm[i] = '0;
    np = 0;
  endtask

  // instruction-level model with issue timing from R7/R8
  task automatic build_expect();
    logic [63:0] r [32];
    logic [63:0] m [64];
    logic [63:0] pc = '0;
    logic [63:0] va, vb, addr, res;
    logic [31:0] ins;
    int id = 0, pld = 0, a, b, d, kind;
    bit pbr = 0, stall;
    logic [1:0] u;
    for (int i = 0; i < MAXC; i++) begin ewe[i] = 0; ea[i] = '0; ed[i] = '0; ereq[i] = "R9"; end
    for (int i = 0; i < 32; i++) r[i] = '0;
    for (int i = 0; i < 64; i++) m[i] = dm[i];
    for (int step = 0; step < 3000; step++) begin
      ins = im[pc[9:2]];
      a = int'(ins[19:15]); b = int'(ins[24:20]); d = int'(ins[11:7]);
      kind = 0; u = 2'b00; res = '0;
      if (ins[6:0] == 7'b0000011 && ins[14:12] == 3'b011) begin kind = 1; u = 2'b01; end
      else if (ins[6:0] == 7'b0100011 && ins[14:12] == 3'b011) begin kind = 2; u = 2'b11; end
      else if (ins[6:0] == 7'b1100011 && ins[14:12] == 3'b000) begin kind = 4; u = 2'b11; end
      else if (ins[6:0] == 7'b0110011) begin
        va = r[a]; vb = r[b];
        case ({ins[31:25], ins[14:12]})
          {7'h00, 3'b000}: begin kind = 3; res = va + vb; end
          {7'h20, 3'b000}: begin kind = 3; res = va - vb; end
          {7'h00, 3'b111}: begin kind = 3; res = va & vb; end
          {7'h00, 3'b110}: begin kind = 3; res = va | vb; end
          default: kind = 0;
        endcase
        if (kind == 3) u = 2'b11;
      end
      stall = (pld != 0) && ((u[0] && a == pld) || (u[1] && b == pld));
      id = (step == 0) ? 1 : id + 1 + (stall ? 1 : 0) + (pbr ? 2 : 0);
      va = r[a]; vb = r[b];
      pc = pc + 64'd4;
      case (kind)
        1: begin
          addr = va + {{52{ins[31]}}, ins[31:20]};
          if (d != 0) r[d] = m[addr[8:3]];
        end
        2: begin
          addr = va + {{52{ins[31]}}, ins[31:25], ins[11:7]};
          m[addr[8:3]] = vb;
          if (id + 2 < MAXC) begin
            ewe[id+2] = 1; ea[id+2] = addr; ed[id+2] = vb; ereq[id+2] = itag[(pc[9:2] - 8'd1)];
          end
        end
        3: if (d != 0) r[d] = res;
        4: begin
          addr = {{51{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
          if (va == vb) begin
            if (addr == '0) break;
            pc = pc - 64'd4 + addr;
          end
        end
        default: ;
      endcase
      pld = (kind == 1) ? d : 0;
      pbr = (kind == 4);
    end
  endtask

  task automatic run_prog();
    @(negedge clk);
    n_chk++;  // R1: reset holds fetch at 0 and the store strobe low
    if (imem_addr !== 64'h0 || dmem_we !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: imem_addr=%h dmem_we=%b expected 0 0", imem_addr, dmem_we);
    end
    build_expect();
    rst = 1'b0;
    for (int c = 1; c <= RUN; c++) begin
      @(negedge clk);
      n_chk++;
      if (dmem_we !== ewe[c] ||
          (ewe[c] && (dmem_addr !== ea[c] || dmem_wdata !== ed[c]))) begin
        n_bad++;
        $display("FAIL %s cycle %0d: we=%b addr=%h data=%h expected we=%b addr=%h data=%h",
                 ereq[c], c, dmem_we, dmem_addr, dmem_wdata, ewe[c], ea[c], ed[c]);
      end
    end
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);

    // program 1: forwarding, priority, x0, write-before-read, load-use
    clear_mem();
    dm[0] = 64'd100; dm[1] = 64'h0F0F; dm[3] = 64'd64; dm[9] = 64'h1234_5678_9ABC_DEF0;
    put(e_ld(1, 0, 0), "R9");
    put(e_ld(2, 0, 8), "R9");
    put(e_add(3, 1, 2), "R7");
    put(e_sub(4, 3, 1), "R3");
    put(e_and(5, 4, 3), "R3");
    put(e_add(6, 1, 1), "R4");
    put(e_add(6, 6, 2), "R4");
    put(e_add(7, 6, 6), "R4");
    put(e_or(8, 7, 5), "R3");
    put(e_add(0, 1, 2), "R5");
    put(e_add(9, 0, 1), "R5");
    put(32'h0050_0093, "R2");   // outside the subset: no effect on x1
    put(e_add(13, 1, 2), "R6");
    put(e_or(15, 5, 5), "R6");
    put(e_and(16, 4, 4), "R3");
    put(e_add(14, 13, 13), "R6");
    put(e_ld(11, 0, 24), "R9");
    put(e_ld(12, 11, 8), "R7");
    put(e_sd(12, 11, -8), "R9");
    put(e_sd(3, 0, 96), "R7");
    put(e_sd(4, 0, 104), "R3");
    put(e_sd(5, 0, 112), "R3");
    put(e_sd(7, 0, 120), "R4");
    put(e_sd(8, 0, 128), "R3");
    put(e_sd(9, 0, 136), "R5");
    put(e_sd(0, 0, 144), "R5");
    put(e_sd(1, 0, 152), "R2");
    put(e_sd(14, 0, 160), "R6");
    put(e_sd(16, 0, 168), "R3");
    put(e_beq(0, 0, 0), "R8");
    run_prog();

    // program 2: branches (R8), taken/not taken, forward/backward, after load-use
    clear_mem();
    dm[0] = 64'd7; dm[1] = 64'd7; dm[2] = 64'd1;
    put(e_ld(6, 0, 16), "R9");
    put(e_ld(1, 0, 0), "R9");
    put(e_ld(2, 0, 8), "R9");
    put(e_beq(1, 2, 12), "R8");
    put(e_add(3, 1, 1), "R8");
    put(e_sd(3, 0, 64), "R8");
    put(e_sub(4, 1, 2), "R8");
    put(e_beq(4, 1, 8), "R8");
    put(e_sd(4, 0, 72), "R8");
    put(e_add(5, 6, 6), "R8");
    put(e_sub(5, 5, 6), "R8");
    put(e_sd(5, 0, 80), "R8");
    put(e_beq(5, 0, 8), "R8");
    put(e_beq(0, 0, -12), "R8");
    put(e_sd(1, 0, 88), "R8");
    put(e_beq(0, 0, 0), "R8");
    run_prog();

    // programs 3..5: drawn dependence chains (R3)
    for (int p = 0; p < 3; p++) begin
      clear_mem();
      for (int i = 0; i < 16; i++) dm[i] = {$urandom, $urandom};
      for (int i = 1; i < 8; i++) put(e_ld(i, 0, 8 * i), "R9");
      for (int k = 0; k < 40; k++) begin
        int sel = int'($urandom % 8);
        int d = int'($urandom % 8);
        int a = int'($urandom % 8);
        int b = int'($urandom % 8);
        case (sel)
          0: put(e_add(d, a, b), "R3");
          1: put(e_sub(d, a, b), "R3");
          2: put(e_and(d, a, b), "R3");
          3: put(e_or(d, a, b), "R3");
          4: put(e_add(d, a, b), "R4");
          5: put(e_ld(d, 0, 8 * int'($urandom % 16)), "R7");
          6: put(e_sd(b, 0, 8 * (8 + int'($urandom % 8))), "R3");
          default: put(e_sub(d, b, a), "R3");
        endcase
      end
      for (int i = 1; i < 8; i++) put(e_sd(i, 0, 8 * (16 + i)), "R3");
      put(e_beq(0, 0, 0), "R8");
      run_prog();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule